// File: doc/BRIEF.md
# Flash descriptor readout sequencer

This block answers a "get descriptor" command with a fixed, parameter-defined description of a flash array. The description comes back one 32-bit word at a time. Software writes the command opcode through a command write strobe. It then pulls words by pulsing a result read strobe. The result bus always shows the word at the current read position, and each read strobe moves that position forward by one.

The description contains the following, in order:
- an interface identifier;
- the total size in bytes;
- the page size in bytes;
- the plane count, followed by one size word per plane;
- the lock-bit count, followed by one size word per lock region.

The length therefore depends on the plane and lock-region counts and is `5 + NUM_PLANES + NUM_LOCKS` words. When the last word has been handed out, the result bus reads zero until a new descriptor command arrives.

Plane and region sizes are supplied as packed parameter vectors, one 32-bit field per entry. Entry 0, the first plane or first region, sits in bits [31:0]. The word table is built at elaboration from these parameters.

Top module: `flash_desc_seq`

## Requirements
- R1: After reset, with no command written, `res_data` is 0.
- R2: After a command write with `cmd_op == GET_OP`, word 0 is the identifier, word 1 is the flash size in bytes, word 2 is the page size in bytes, and word 3 is the plane count. Each word appears on `res_data` before the read strobe that consumes it.
- R3: Words 4 to 3+NUM_PLANES carry the plane sizes, first plane first. Plane p is taken from `PLANE_SIZES[32*p +: 32]`.
- R4: Word 4+NUM_PLANES is the lock-bit count. It is followed by one word per lock region, first region first. Region r is taken from `LOCK_SIZES[32*r +: 32]`.
- R5: Once all 5+NUM_PLANES+NUM_LOCKS words have been read, every further read returns 0 until the next `GET_OP` command.
- R6: A `GET_OP` command written in the middle of a readout restarts it at word 0. If a command write and a read strobe fall in the same cycle, the command wins.
- R7: The read position moves only on a cycle with `res_rd` high. Idle cycles between reads leave it unchanged, and back-to-back reads return consecutive words.
- R8: While no descriptor command is active, a read returns 0 and moves no position. A later `GET_OP` still starts at word 0.
- R9: A command write with any opcode other than `GET_OP` leaves an active readout at its current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_op | input | CMD_W | Opcode written with `cmd_wr` |
| res_rd | input | 1 | Result register read strobe |
| res_data | output | 32 | Word at the current read position, or 0 |

## Verification
Some properties are checked by assertions on every cycle:
- the read position saturates at the end;
- the position holds on idle and non-descriptor cycles;
- a descriptor command restarts the position at zero;
- the identifier appears right after a command;
- the tail and the inactive state read zero.

The content of each plane and lock-region word, and its order, is shown only by the bench. It sweeps every word of two configurations with different plane and lock counts, and it exercises a mid-readout restart, a command that collides with a read, a foreign opcode and idle gaps.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned HDR_WORDS = 4;    // id, size, page, plane count
   typedef logic [WORD_W-1:0] word_t;

   function automatic int unsigned desc_words(input int unsigned np, input int unsigned nl);
      return HDR_WORDS + np + 1 + nl;
   endfunction
endpackage

// File: rtl/fdesc_word_table.sv
module fdesc_word_table
   import fdesc_pkg::*;
#(
   parameter logic [31:0] ID_WORD     = 32'h0,
   parameter int unsigned FLASH_BYTES = 65536,
   parameter int unsigned PAGE_BYTES  = 256,
   parameter int unsigned NUM_PLANES  = 1,
   parameter logic [NUM_PLANES*32-1:0] PLANE_SIZES = '0,
   parameter int unsigned NUM_LOCKS   = 1,
   parameter logic [NUM_LOCKS*32-1:0]  LOCK_SIZES  = '0,
   parameter int unsigned IDX_W       = 4
) (
   input  logic [IDX_W-1:0] idx,
   output word_t            word
);
   localparam int unsigned LEN      = desc_words(NUM_PLANES, NUM_LOCKS);
   localparam int unsigned DEPTH    = 1 << IDX_W;
   localparam int unsigned PL_FIRST = HDR_WORDS;
   localparam int unsigned LK_CNT   = HDR_WORDS + NUM_PLANES;
   localparam int unsigned LK_FIRST = LK_CNT + 1;

   initial begin
      if (DEPTH < LEN + 1) $error("fdesc_word_table: IDX_W too small");
   end

   word_t tbl [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      if (g == 0) begin : g_id
         assign tbl[g] = ID_WORD;
      end else if (g == 1) begin : g_fsz
         assign tbl[g] = word_t'(FLASH_BYTES);
      end else if (g == 2) begin : g_psz
         assign tbl[g] = word_t'(PAGE_BYTES);
      end else if (g == 3) begin : g_npl
         assign tbl[g] = word_t'(NUM_PLANES);
      end else if (g < LK_CNT) begin : g_pl
         assign tbl[g] = PLANE_SIZES[32*(g-PL_FIRST) +: 32];
      end else if (g == LK_CNT) begin : g_nlk
         assign tbl[g] = word_t'(NUM_LOCKS);
      end else if (g < LEN) begin : g_lk
         assign tbl[g] = LOCK_SIZES[32*(g-LK_FIRST) +: 32];
      end else begin : g_tail
         assign tbl[g] = '0;
      end
   end

   assign word = tbl[idx];
endmodule

// File: rtl/fdesc_index_ctrl.sv
module fdesc_index_ctrl #(
   parameter int unsigned LEN    = 10,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned CMD_W  = 8,
   parameter logic [CMD_W-1:0] GET_OP = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_op,
   input  logic             res_rd,
   output logic             active,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN);

   logic get_hit, step;
   assign get_hit = cmd_wr && (cmd_op == GET_OP);
   assign step    = res_rd && active && (idx != LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (get_hit) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (step) begin
         idx    <= idx + IDX_W'(1);
      end
   end

   // R5: the position saturates once the tail is reached
   a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == LAST && !get_hit) |=> idx == LAST);
   // R6: a descriptor command restarts at word 0
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      get_hit |=> (idx == '0 && active));
   // R7, R9: no read and no descriptor command leaves the position alone
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_rd && !get_hit) |=> $stable(idx));
   // R8: reads while inactive do not move anything
   a_r8_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !get_hit) |=> (!active && idx == '0));
   a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST);
endmodule

// File: rtl/flash_desc_seq.sv
module flash_desc_seq
   import fdesc_pkg::*;
#(
   parameter int unsigned CMD_W       = 8,
   parameter logic [CMD_W-1:0] GET_OP = 8'h21,
   parameter logic [31:0] ID_WORD     = 32'hF1A5_0001,
   parameter int unsigned FLASH_BYTES = 65536,
   parameter int unsigned PAGE_BYTES  = 256,
   parameter int unsigned NUM_PLANES  = 1,
   parameter logic [NUM_PLANES*32-1:0] PLANE_SIZES = 32'h0001_0000,
   parameter int unsigned NUM_LOCKS   = 4,
   parameter logic [NUM_LOCKS*32-1:0]  LOCK_SIZES  = {4{32'h0000_4000}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_op,
   input  logic             res_rd,
   output logic [31:0]      res_data
);
   localparam int unsigned LEN   = desc_words(NUM_PLANES, NUM_LOCKS);
   localparam int unsigned IDX_W = $clog2(LEN + 1);

   initial begin
      if (NUM_PLANES < 1) $error("flash_desc_seq: NUM_PLANES must be at least 1");
      if (NUM_LOCKS < 1)  $error("flash_desc_seq: NUM_LOCKS must be at least 1");
      if (CMD_W < 1)      $error("flash_desc_seq: CMD_W must be at least 1");
   end

   logic             active;
   logic [IDX_W-1:0] idx;
   word_t            word;

   fdesc_index_ctrl #(
      .LEN(LEN), .IDX_W(IDX_W), .CMD_W(CMD_W), .GET_OP(GET_OP)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
      .res_rd(res_rd), .active(active), .idx(idx)
   );

   fdesc_word_table #(
      .ID_WORD(ID_WORD), .FLASH_BYTES(FLASH_BYTES), .PAGE_BYTES(PAGE_BYTES),
      .NUM_PLANES(NUM_PLANES), .PLANE_SIZES(PLANE_SIZES),
      .NUM_LOCKS(NUM_LOCKS), .LOCK_SIZES(LOCK_SIZES), .IDX_W(IDX_W)
   ) table_i (
      .idx(idx), .word(word)
   );

   assign res_data = active ? word : '0;

   // R2: the identifier is on the bus right after a descriptor command
   a_r2_id_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_op == GET_OP) |=> res_data == ID_WORD);
   // R5: the tail reads zero
   a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == IDX_W'(LEN)) |-> res_data == '0);
   // R1, R8: nothing is shown before a command
   a_r8_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> res_data == '0);
endmodule

// File: tb/flash_desc_seq_tb.sv
module flash_desc_seq_tb_top;
   localparam logic [7:0] GOP = 8'h21;
   // configuration A
   localparam logic [31:0] ID_A = 32'hF1A5_0001;
   localparam int unsigned FS_A = 65536, PG_A = 256, NP_A = 1, NL_A = 4;
   localparam logic [NP_A*32-1:0] PL_A = 32'h0001_0000;
   localparam logic [NL_A*32-1:0] LK_A = {32'h4000, 32'h3000, 32'h5000, 32'h4000};
   localparam int unsigned LEN_A = 5 + NP_A + NL_A;
   // configuration B
   localparam logic [31:0] ID_B = 32'h0BAD_C0DE;
   localparam int unsigned FS_B = 131072, PG_B = 512, NP_B = 3, NL_B = 3;
   localparam logic [NP_B*32-1:0] PL_B = {32'h8000, 32'h0001_0000, 32'h8000};
   localparam logic [NL_B*32-1:0] LK_B = {32'h1000, 32'h3000, 32'h0001_C000};
   localparam int unsigned LEN_B = 5 + NP_B + NL_B;

   logic clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0, res_rd = 1'b0;
   logic [7:0] cmd_op = '0;
   logic [31:0] data_a, data_b;
   int tests = 0, fails = 0;
   int pos_a = 0, pos_b = 0;   // bench model of positions, -1 = inactive

   always #4 clk = ~clk;   // 125 MHz

   flash_desc_seq #(.GET_OP(GOP), .ID_WORD(ID_A), .FLASH_BYTES(FS_A), .PAGE_BYTES(PG_A),
      .NUM_PLANES(NP_A), .PLANE_SIZES(PL_A), .NUM_LOCKS(NL_A), .LOCK_SIZES(LK_A)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .res_rd(res_rd), .res_data(data_a));

   flash_desc_seq #(.GET_OP(GOP), .ID_WORD(ID_B), .FLASH_BYTES(FS_B), .PAGE_BYTES(PG_B),
      .NUM_PLANES(NP_B), .PLANE_SIZES(PL_B), .NUM_LOCKS(NL_B), .LOCK_SIZES(LK_B)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .res_rd(res_rd), .res_data(data_b));

   function automatic logic [31:0] exp_word(input int i, input logic [31:0] id, input int fs,
      input int pg, input int np, input logic [255:0] pl, input int nl, input logic [255:0] lk);
      if (i < 0) return 32'h0;
      if (i == 0) return id;
      if (i == 1) return 32'(fs);
      if (i == 2) return 32'(pg);
      if (i == 3) return 32'(np);
      if (i < 4 + np) return pl[32*(i-4) +: 32];
      if (i == 4 + np) return 32'(nl);
      if (i < 5 + np + nl) return lk[32*(i-5-np) +: 32];
      return 32'h0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic check_both(input string req);
      check({req, " cfgA"}, data_a, exp_word(pos_a, ID_A, FS_A, PG_A, NP_A, 256'(PL_A), NL_A, 256'(LK_A)));
      check({req, " cfgB"}, data_b, exp_word(pos_b, ID_B, FS_B, PG_B, NP_B, 256'(PL_B), NL_B, 256'(LK_B)));
   endtask

   // one bus cycle: optional command and/or read, then check the resulting bus
   task automatic cycle(input logic wr, input logic [7:0] op, input logic rd, input string req);
      @(negedge clk);
      check_both(req);
      cmd_wr = wr; cmd_op = op; res_rd = rd;
      @(posedge clk); #1;
      cmd_wr = 1'b0; res_rd = 1'b0;
      if (wr && op == GOP) begin
         pos_a = 0; pos_b = 0;
      end else if (rd) begin
         if (pos_a >= 0 && pos_a < LEN_A) pos_a++;
         if (pos_b >= 0 && pos_b < LEN_B) pos_b++;
      end
   endtask

   initial begin
      pos_a = -1; pos_b = -1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cycle(0, 8'h00, 0, "R1 reset");
      // R8: reads while inactive
      cycle(0, 8'h00, 1, "R8 inactive read");
      cycle(0, 8'h00, 1, "R8 inactive read");
      // R2 R3 R4 R5: full sweep, past the end
      cycle(1, GOP, 0, "R8 before first command");
      for (int k = 0; k < 16; k++) cycle(0, 8'h00, 1, "R2 R3 R4 R5 sweep");
      cycle(0, 8'h00, 0, "R5 tail zero");
      // R6: restart mid-readout
      cycle(1, GOP, 0, "R5 zero until command");
      for (int k = 0; k < 4; k++) cycle(0, 8'h00, 1, "R6 partial");
      cycle(1, GOP, 0, "R6 before restart");
      cycle(0, 8'h00, 1, "R6 restart word0");
      cycle(0, 8'h00, 1, "R6 restart word1");
      // R6: command and read collide, command wins
      cycle(1, GOP, 1, "R6 before collision");
      cycle(0, 8'h00, 1, "R6 collision word0");
      // R9: foreign opcodes leave the position
      cycle(1, 8'h33, 0, "R9 before foreign op");
      cycle(1, 8'h20, 1, "R9 foreign op with read");
      cycle(0, 8'h00, 1, "R9 after foreign op");
      // R7: idle gaps, then consecutive reads
      for (int k = 0; k < 5; k++) cycle(0, 8'h00, 0, "R7 idle hold");
      for (int k = 0; k < 14; k++) cycle(0, 8'h00, (k % 3) != 1, "R7 gapped reads");
      cycle(0, 8'h00, 0, "R5 final tail");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule